// File: doc/BRIEF.md
# Mode-selectable bidirectional inverting transceiver

This block is the logic core of a 9-bit transceiver that sits between a three-state A side and an open-collector B side. Each direction has its own storage element, chosen by a shared two-bit select. The element is a straight wire, a transparent latch or an edge-triggered register. Data is inverted on its way through, whichever element is active. Each direction has its own clock input. That input is the capture edge in register mode and a latch enable in latch mode. The latch is open while the input is Low and holds while it is High.

The block runs on one system clock. The per-direction clock inputs are sampled on that clock. A register captures in the cycle where its direction clock is seen High after a sampled Low. A latch loads in every cycle while its enable is Low, and its output follows the input in the same cycle. The open-collector B side is modelled as a per-bit pull-down request, and the resolved bus value comes back in on `bIn`. The A side is modelled as a data bus plus an enable. While the A side is disabled its data bus reads zero.

Top module: `inv_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears both stored values to zero. With the elements closed after reset, both directions present all ones, and no pull-down is requested.
- R2: The select codes work as follows, with `modeSel[1]` written first. 2'b10 gives straight-through in both directions. 2'b00 gives latches in both directions. 2'b01 gives registers in both directions. 2'b11 gives a register from A to B and a latch from B to A.
- R3: In every mode, each output bit is the logical inverse of the input bit that is passed or stored.
- R4: In register mode, a direction stores its input in the system-clock cycle where its direction clock is sampled High after a sampled Low. The new value appears from the next cycle. At all other times the value is held.
- R5: In latch mode, while a direction's clock input is Low, the output follows the inverted input in the same cycle and the latch is reloaded every cycle. While the clock input is High, the last loaded value is held.
- R6: `bPullDown[i]` is 1 only when `bEnHigh`=1, `bEnLow`=0 and the A-to-B value bit i is 0. Otherwise every pull-down bit is 0, which releases the bus to its pull-up (logic High).
- R7: `aOutEn` equals `aEnable`. While `aEnable`=0, `aOut` is all zeros.
- R8: Latches and registers keep loading, or keep holding, while their output side is disabled.
- R9: Changing `modeSel` switches the output to the newly selected element at once. It does not change the stored contents.
- R10: In straight-through mode, each output follows its input in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the direction clocks and updates the storage |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Element select code (see R2) |
| aIn | input | WIDTH | Data arriving on the A side |
| abClk | input | 1 | A-to-B capture clock / latch enable (open while Low) |
| baClk | input | 1 | B-to-A capture clock / latch enable (open while Low) |
| aEnable | input | 1 | A side drive enable, active High |
| bEnHigh | input | 1 | B side enable, active High |
| bEnLow | input | 1 | B side enable, active Low |
| bIn | input | WIDTH | Resolved value of the B bus |
| aOut | output | WIDTH | Data driven on the A side, zero while disabled |
| aOutEn | output | 1 | A side drive enable |
| bPullDown | output | WIDTH | Per-bit pull-down request on the B bus |

## Verification
The assertions assume that every input, the direction clocks included, changes only between rising edges of `clk` and stays stable across each edge. Under that assumption, one sampled value per cycle is the whole truth about a direction clock, so an edge or an open latch can be judged from samples alone. They also assume that `bIn` is the resolved bus value, not an independent stimulus. The bench changes every input on the falling edge of `clk` and holds it for a full period. It builds `bIn` from the block's own pull-down requests together with external pull-downs.

// File: rtl/inv_xcvr_pkg.sv
package inv_xcvr_pkg;

  typedef enum logic [1:0] {
    ELEM_THRU  = 2'd0,
    ELEM_LATCH = 2'd1,
    ELEM_REG   = 2'd2
  } elem_e;

  // Per-direction strobes from control to datapath
  typedef struct packed {
    elem_e elem;   // active element
    logic  load;   // update the stored value at this clock
    logic  open;   // latch transparent this cycle
  } dirStrobe_t;

  typedef struct packed {
    dirStrobe_t toB;
    dirStrobe_t toA;
  } strobe_t;

  localparam logic [1:0] SEL_LATCH = 2'b00;
  localparam logic [1:0] SEL_REG   = 2'b01;
  localparam logic [1:0] SEL_THRU  = 2'b10;
  localparam logic [1:0] SEL_SPLIT = 2'b11;

  function automatic elem_e elemToB(logic [1:0] sel);
    elem_e e;
    case (sel)
      SEL_THRU:  e = ELEM_THRU;
      SEL_LATCH: e = ELEM_LATCH;
      default:   e = ELEM_REG;
    endcase
    return e;
  endfunction

  function automatic elem_e elemToA(logic [1:0] sel);
    elem_e e;
    case (sel)
      SEL_THRU: e = ELEM_THRU;
      SEL_REG:  e = ELEM_REG;
      default:  e = ELEM_LATCH;
    endcase
    return e;
  endfunction

  function automatic dirStrobe_t buildStrobe(elem_e e, logic lvl, logic prev);
    dirStrobe_t s;
    s.elem = e;
    s.open = (e == ELEM_LATCH) && !lvl;
    s.load = s.open || ((e == ELEM_REG) && lvl && !prev);
    return s;
  endfunction

endpackage

// File: rtl/inv_xcvr_ctrl.sv
module inv_xcvr_ctrl
  import inv_xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       abClk,
  input  logic       baClk,
  output strobe_t    strobes
);

  // Previous sampled direction clocks; reset High so a clock that is
  // already High when reset is released is not taken as an edge.
  logic abPrev;
  logic baPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abPrev <= 1'b1;
      baPrev <= 1'b1;
    end else begin
      abPrev <= abClk;
      baPrev <= baClk;
    end
  end

  always_comb begin
    strobes.toB = buildStrobe(elemToB(modeSel), abClk, abPrev);
    strobes.toA = buildStrobe(elemToA(modeSel), baClk, baPrev);
  end

endmodule

// File: rtl/inv_xcvr_stage.sv
module inv_xcvr_stage
  import inv_xcvr_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  input  dirStrobe_t       ctl,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] held;
  logic             passLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         held <= '0;
    else if (ctl.load) held <= din;
  end

  assign passLive = (ctl.elem == ELEM_THRU) || ctl.open;
  assign dout     = ~(passLive ? din : held);

endmodule

// File: rtl/inv_xcvr_datapath.sv
module inv_xcvr_datapath
  import inv_xcvr_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] abValue,
  output logic [WIDTH-1:0] baValue
);

  inv_xcvr_stage #(.WIDTH(WIDTH)) u_toB (
    .clk (clk),
    .rstN(rstN),
    .din (aIn),
    .ctl (strobes.toB),
    .dout(abValue)
  );

  inv_xcvr_stage #(.WIDTH(WIDTH)) u_toA (
    .clk (clk),
    .rstN(rstN),
    .din (bIn),
    .ctl (strobes.toA),
    .dout(baValue)
  );

endmodule

// File: rtl/inv_xcvr.sv
module inv_xcvr
  import inv_xcvr_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [WIDTH-1:0] aIn,
  input  logic             abClk,
  input  logic             baClk,
  input  logic             aEnable,
  input  logic             bEnHigh,
  input  logic             bEnLow,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic [WIDTH-1:0] bPullDown
);

  strobe_t          strobes;
  logic [WIDTH-1:0] abValue;
  logic [WIDTH-1:0] baValue;
  logic             bActive;

  inv_xcvr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .abClk  (abClk),
    .baClk  (baClk),
    .strobes(strobes)
  );

  inv_xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .aIn    (aIn),
    .bIn    (bIn),
    .abValue(abValue),
    .baValue(baValue)
  );

  // Open collector: a Low bit pulls the line, a High bit releases it
  assign bActive   = bEnHigh && !bEnLow;
  assign bPullDown = bActive ? ~abValue : '0;

  assign aOutEn = aEnable;
  assign aOut   = aEnable ? baValue : '0;

endmodule

// File: rtl/inv_xcvr_chk.sv
module inv_xcvr_chk
  import inv_xcvr_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic [WIDTH-1:0] aIn,
  input logic             abClk,
  input logic             baClk,
  input logic             aEnable,
  input logic             bEnHigh,
  input logic             bEnLow,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] bPullDown,
  input logic [WIDTH-1:0] abValue,
  input logic [WIDTH-1:0] baValue
);

  logic seenAbLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenAbLow <= 1'b0;
    else       seenAbLow <= !abClk;
  end

  // R6: a disabled B side never pulls the bus
  p_bdrive_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(bEnHigh && !bEnLow) |-> (bPullDown == '0));

  // R6 / R3: straight-through, enabled: a High A bit becomes a pulled line
  p_bdrive_thru_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == SEL_THRU && bEnHigh && !bEnLow) |-> (bPullDown == aIn));

  // R7: A side data is quiet while disabled
  p_adrive_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !aEnable |-> (aOut == '0));

  // R4: register capture becomes visible one cycle after the sampled edge
  p_reg_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[0] && abClk && seenAbLow) |=> (!modeSel[0] || abValue == ~$past(aIn)));

  // R5: an open B-to-A latch is transparent in the same cycle
  p_latch_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == SEL_LATCH || modeSel == SEL_SPLIT) && !baClk) |-> (baValue == ~bIn));

  // R10: straight-through in both directions
  p_thru_both_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == SEL_THRU) |-> (abValue == ~aIn && baValue == ~bIn));

endmodule

bind inv_xcvr inv_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/inv_xcvr_bench.sv
module inv_xcvr_bench;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rstN;
  logic [1:0]   modeSel;
  logic [W-1:0] aIn;
  logic         abClk, baClk, aEnable, bEnHigh, bEnLow;
  logic [W-1:0] extPull;
  logic [W-1:0] bBus;
  logic [W-1:0] aOut;
  logic         aOutEn;
  logic [W-1:0] bPullDown;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // reference model state
  logic [W-1:0] mAb, mBa;
  logic         mPrevAb, mPrevBa;

  always #5 clk = ~clk;

  assign bBus = ~(bPullDown | extPull);

  inv_xcvr #(.WIDTH(W)) u_inv_xcvr (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .aIn(aIn),
    .abClk(abClk), .baClk(baClk), .aEnable(aEnable),
    .bEnHigh(bEnHigh), .bEnLow(bEnLow), .bIn(bBus),
    .aOut(aOut), .aOutEn(aOutEn), .bPullDown(bPullDown)
  );

  // 0 = straight, 1 = latch, 2 = register  (codes per R2)
  function automatic int kindToB(logic [1:0] s);
    return (s == 2'b10) ? 0 : (s == 2'b00) ? 1 : 2;
  endfunction
  function automatic int kindToA(logic [1:0] s);
    return (s == 2'b10) ? 0 : (s == 2'b01) ? 2 : 1;
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Called just after a falling edge with inputs set; checks, then advances one cycle.
  task automatic step(string tag);
    int kb, ka;
    logic [W-1:0] vAb, vBa, pull, bus;
    #1;
    kb = kindToB(modeSel);
    ka = kindToA(modeSel);
    vAb  = (kb == 0 || (kb == 1 && !abClk)) ? ~aIn : ~mAb;
    pull = (bEnHigh && !bEnLow) ? ~vAb : '0;
    bus  = ~(pull | extPull);
    vBa  = (ka == 0 || (ka == 1 && !baClk)) ? ~bus : ~mBa;
    check(tag, "bPullDown", bPullDown, pull);
    check(tag, "aOut", aOut, aEnable ? vBa : '0);
    check(tag, "aOutEn", W'(aOutEn), W'(aEnable));
    @(posedge clk);
    if ((kb == 2 && abClk && !mPrevAb) || (kb == 1 && !abClk)) mAb = aIn;
    if ((ka == 2 && baClk && !mPrevBa) || (ka == 1 && !baClk)) mBa = bus;
    mPrevAb = abClk;
    mPrevBa = baClk;
    @(negedge clk);
  endtask

  function automatic string modeTag(logic [1:0] s);
    case (s)
      2'b00:   return "R5";
      2'b01:   return "R4";
      2'b10:   return "R10";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; modeSel = 2'b01; aIn = '0; abClk = 1'b0; baClk = 1'b0;
    aEnable = 1'b1; bEnHigh = 1'b1; bEnLow = 1'b0; extPull = '0;
    mAb = '0; mBa = '0; mPrevAb = 1'b1; mPrevBa = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, registers closed
    step("R1");
    check("R1", "aOut all ones", aOut, '1);

    // R4: register capture on sampled rising edge, hold otherwise
    aIn = 9'h0A5; step("R4");
    abClk = 1'b1; step("R4");
    aIn = 9'h15A; step("R4");
    abClk = 1'b0; step("R4");
    extPull = 9'h0F0; baClk = 1'b1; step("R4");
    extPull = 9'h00F; step("R4");
    baClk = 1'b0; step("R4");

    // R5: latch transparency and hold
    modeSel = 2'b00; abClk = 1'b0; baClk = 1'b0;
    aIn = 9'h1C3; step("R5");
    aIn = 9'h03C; step("R5");
    abClk = 1'b1; baClk = 1'b1; step("R5");
    aIn = 9'h1FF; extPull = 9'h155; step("R5");

    // R10 / R3: straight-through, walking ones on both sides
    modeSel = 2'b10;
    for (int i = 0; i < W; i++) begin
      aIn = W'(1) << i; extPull = W'(1) << ((i + 3) % W);
      step("R10");
    end
    bEnHigh = 1'b0;
    for (int i = 0; i < W; i++) begin
      aIn = ~(W'(1) << i); extPull = W'(1) << i;
      step("R3");
    end
    bEnHigh = 1'b1;

    // R6: all four B enable combinations, every bit would pull
    aIn = '1; extPull = '0;
    for (int e = 0; e < 4; e++) begin
      bEnHigh = e[0]; bEnLow = e[1];
      step("R6");
    end
    bEnHigh = 1'b1; bEnLow = 1'b0;

    // R7: A side disabled
    aEnable = 1'b0; aIn = 9'h0F1; step("R7");
    check("R7", "aOut quiet", aOut, '0);
    aEnable = 1'b1;

    // R2: split code, register A-to-B, latch B-to-A
    modeSel = 2'b11; abClk = 1'b0; baClk = 1'b0; aIn = 9'h111; step("R2");
    abClk = 1'b1; extPull = 9'h0AA; step("R2");
    aIn = 9'h0EE; baClk = 1'b1; step("R2");
    extPull = 9'h000; step("R2");

    // R8: load with both outputs disabled, then reveal
    modeSel = 2'b01; abClk = 1'b0; baClk = 1'b0; aEnable = 1'b0; bEnLow = 1'b1;
    step("R8");
    aIn = 9'h123; extPull = 9'h0C4; abClk = 1'b1; baClk = 1'b1; step("R8");
    aIn = 9'h000; extPull = 9'h000; aEnable = 1'b1; bEnLow = 1'b0; step("R8");

    // R9: mode changes leave stored contents alone
    modeSel = 2'b10; aIn = 9'h1AB; step("R9");
    modeSel = 2'b00; step("R9");
    modeSel = 2'b01; step("R9");
    modeSel = 2'b11; step("R9");

    // near-exhaustive sweep of all select codes with varied stimulus
    for (int m = 0; m < 4; m++) begin
      modeSel = 2'(m);
      for (int n = 0; n < 400; n++) begin
        aIn = W'($urandom); extPull = (n % 3 == 0) ? W'($urandom) : '0;
        abClk = 1'($urandom); baClk = 1'($urandom);
        aEnable = (n % 7) != 0; bEnHigh = (n % 5) != 0; bEnLow = (n % 11) == 0;
        step(modeTag(modeSel));
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule